// File: doc/BRIEF.md
# Floating-Point Issue Interlock

This block sits at the issue stage of an in-order pipeline. The pipeline issues integer, floating-point ALU, load-double and store-double instructions. Each cycle the issue stage presents at most one instruction: its class, its floating-point destination and two floating-point source indices. The block tracks, for every floating-point register, which class of instruction last wrote it and how many cycles remain before that result may be read. When the presented instruction reads a register too early, the block raises a stall in the same cycle. The issue stage then holds the same instruction until the stall clears.

The required distance depends on the pair of producer class and consumer class. A store can take a floating-point ALU result one cycle earlier than an ALU operation can, and it can take a loaded value with no gap at all. The integer class covers integer arithmetic, branches and the single branch delay-slot instruction, which always issues. That class neither reads nor writes the floating-point registers and never stalls. A saturating counter of stalled cycles lets a test compare the stalls each loop iteration costs.

Top module: `fp_interlock`

## Requirements
- R1: After reset, `stall` and `stall_cnt` are 0 and no register is pending, so the first consumer of any register issues without a stall.
- R2: `iss_cls` encoding: 0 = integer/branch/delay slot (no floating-point reads or writes); 1 = floating-point ALU (reads `iss_src_a` and `iss_src_b`, writes `iss_dst`); 2 = load double (writes `iss_dst`, reads no floating-point register); 3 = store double (reads `iss_src_a` as its data, nothing else).
- R3: A floating-point ALU consumer issued directly after a floating-point ALU producer of one of its sources is stalled for 3 cycles.
- R4: A store-double issued directly after a floating-point ALU producer of its data register is stalled for 2 cycles.
- R5: A floating-point ALU consumer issued directly after a load-double producer of one of its sources is stalled for 1 cycle.
- R6: A store-double issued directly after a load-double producer of its data register is not stalled.
- R7: The separation counts every cycle since the producer issued, so each independent instruction placed in between removes one stall cycle.
- R8: Sources that a class does not read are ignored: a store's `iss_src_b`, all sources of a load and all sources of an integer instruction never cause a stall.
- R9: The most recently issued producer of a register sets its latency, and this replaces any older pending producer of the same register.
- R10: `stall` is raised only while `iss_valid` is 1 and in the same cycle as the hazard. A held instruction issues on the first cycle in which `stall` is 0.
- R11: `stall_cnt` increases by one after each cycle in which `stall` is 1, otherwise holds, and saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_cls | input | 2 | Instruction class, encoded as in R2 |
| iss_dst | input | $clog2(NREG) | Floating-point destination register |
| iss_src_a | input | $clog2(NREG) | First floating-point source (store data) |
| iss_src_b | input | $clog2(NREG) | Second floating-point source |
| stall | output | 1 | Hold the presented instruction this cycle |
| stall_cnt | output | CNT_W | Number of stalled cycles so far, saturating |

## Verification
`stall` is combinational on the presented instruction and the register state, so it is due in the same cycle. The bench drives each instruction on the falling edge and reads `stall` shortly after, counting the falling edges spent stalled before the instruction goes through on the next rising edge. A register's pending latency is loaded on the rising edge where its producer issues. The consumer presented on the following falling edge therefore shows exactly the producer/consumer distance in stall cycles. `stall_cnt` takes one rising edge per stalled cycle, so it is compared only at a falling edge after the last instruction of a scenario has issued.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

   typedef enum logic [1:0] {
      CLS_INT = 2'd0,
      CLS_FPU = 2'd1,
      CLS_LDD = 2'd2,
      CLS_STD = 2'd3
   } ilk_cls_e;

   function automatic logic cls_writes_fp(input ilk_cls_e c);
      return (c == CLS_FPU) || (c == CLS_LDD);
   endfunction

   function automatic logic cls_reads_a(input ilk_cls_e c);
      return (c == CLS_FPU) || (c == CLS_STD);
   endfunction

   function automatic logic cls_reads_b(input ilk_cls_e c);
      return (c == CLS_FPU);
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
   import ilk_pkg::*;
#(
   parameter int NREG   = 32,
   parameter int RW     = 5,
   parameter int REM_W  = 2,
   parameter int MAX_FP = 3,
   parameter int MAX_LD = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  ilk_cls_e                    wr_cls,
   input  logic [RW-1:0]               wr_idx,
   output logic [NREG-1:0][REM_W-1:0]  rem_o,
   output logic [NREG-1:0]             tag_fp_o
);

   localparam logic [REM_W-1:0] INIT_FP = REM_W'(MAX_FP);
   localparam logic [REM_W-1:0] INIT_LD = REM_W'(MAX_LD);

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic             hit;
      logic [REM_W-1:0] rem_q;
      logic             tag_q;

      assign hit = wr_en && (wr_idx == RW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem_q <= '0;
            tag_q <= 1'b0;
         end else if (hit) begin
            rem_q <= (wr_cls == CLS_FPU) ? INIT_FP : INIT_LD;
            tag_q <= (wr_cls == CLS_FPU);
         end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
         end
      end

      assign rem_o[i]    = rem_q;
      assign tag_fp_o[i] = tag_q;
   end

endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
   import ilk_pkg::*;
#(
   parameter int NREG   = 32,
   parameter int RW     = 5,
   parameter int REM_W  = 2,
   parameter int LAT_FF = 3,
   parameter int LAT_FS = 2,
   parameter int LAT_LF = 1,
   parameter int LAT_LS = 0,
   parameter int MAX_FP = 3,
   parameter int MAX_LD = 1
) (
   input  logic                        valid,
   input  ilk_cls_e                    cls,
   input  logic [RW-1:0]               src_a,
   input  logic [RW-1:0]               src_b,
   input  logic [NREG-1:0][REM_W-1:0]  rem,
   input  logic [NREG-1:0]             tag_fp,
   output logic                        hazard
);

   // remaining count above which a consumer must wait, per producer/consumer pair
   localparam int THR_FF = MAX_FP - LAT_FF;
   localparam int THR_FS = MAX_FP - LAT_FS;
   localparam int THR_LF = MAX_LD - LAT_LF;
   localparam int THR_LS = MAX_LD - LAT_LS;
   localparam int NSRC   = 2;

   logic [NSRC-1:0][RW-1:0] src;
   logic [NSRC-1:0]         used;
   logic [NSRC-1:0]         need;

   assign src[0]  = src_a;
   assign src[1]  = src_b;
   assign used[0] = cls_reads_a(cls);
   assign used[1] = cls_reads_b(cls);

   for (genvar p = 0; p < NSRC; p++) begin : g_src
      logic [REM_W-1:0] r_sel;
      logic             t_sel;
      int               thr;
      logic             need_q;

      assign r_sel = rem[src[p]];
      assign t_sel = tag_fp[src[p]];

      always_comb begin
         if (t_sel) thr = (cls == CLS_STD) ? THR_FS : THR_FF;
         else       thr = (cls == CLS_STD) ? THR_LS : THR_LF;
         need_q = used[p] && (int'(r_sel) > thr);
      end

      assign need[p] = need_q;
   end

   assign hazard = valid && (|need);

endmodule

// File: rtl/ilk_stall_ctr.sv
module ilk_stall_ctr #(
   parameter int CNT_W   = 16,
   parameter bit SAT_CNT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   logic [CNT_W-1:0] nxt;

   if (SAT_CNT) begin : g_sat
      assign nxt = (cnt == '1) ? cnt : cnt + 1'b1;
   end else begin : g_wrap
      assign nxt = cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (inc) cnt <= nxt;
   end

endmodule

// File: rtl/fp_interlock.sv
module fp_interlock
   import ilk_pkg::*;
#(
   parameter int NREG    = 32,
   parameter int LAT_FF  = 3,
   parameter int LAT_FS  = 2,
   parameter int LAT_LF  = 1,
   parameter int LAT_LS  = 0,
   parameter int CNT_W   = 16,
   parameter bit SAT_CNT = 1'b1,
   localparam int RW     = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iss_valid,
   input  logic [1:0]       iss_cls,
   input  logic [RW-1:0]    iss_dst,
   input  logic [RW-1:0]    iss_src_a,
   input  logic [RW-1:0]    iss_src_b,
   output logic             stall,
   output logic [CNT_W-1:0] stall_cnt
);

   localparam int MAX_FP  = imax(LAT_FF, LAT_FS);
   localparam int MAX_LD  = imax(LAT_LF, LAT_LS);
   localparam int MAX_ALL = imax(MAX_FP, MAX_LD);
   localparam int REM_W   = (MAX_ALL < 1) ? 1 : $clog2(MAX_ALL + 1);

   if (NREG < 2 || (1 << RW) != NREG) begin : g_bad_nreg
      $error("fp_interlock: NREG must be a power of two and at least 2");
   end
   if (LAT_FF < 0 || LAT_FS < 0 || LAT_LF < 0 || LAT_LS < 0) begin : g_bad_lat
      $error("fp_interlock: latencies must not be negative");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("fp_interlock: CNT_W must be at least 1");
   end

   ilk_cls_e                   cls;
   logic [NREG-1:0][REM_W-1:0] rem;
   logic [NREG-1:0]            tag_fp;
   logic                       hazard;
   logic                       wr_en;

   assign cls   = ilk_cls_e'(iss_cls);
   assign stall = hazard;
   assign wr_en = iss_valid && !hazard && cls_writes_fp(cls);

   ilk_scoreboard #(
      .NREG   (NREG),
      .RW     (RW),
      .REM_W  (REM_W),
      .MAX_FP (MAX_FP),
      .MAX_LD (MAX_LD)
   ) u_sb (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_cls   (cls),
      .wr_idx   (iss_dst),
      .rem_o    (rem),
      .tag_fp_o (tag_fp)
   );

   ilk_hazard #(
      .NREG   (NREG),
      .RW     (RW),
      .REM_W  (REM_W),
      .LAT_FF (LAT_FF),
      .LAT_FS (LAT_FS),
      .LAT_LF (LAT_LF),
      .LAT_LS (LAT_LS),
      .MAX_FP (MAX_FP),
      .MAX_LD (MAX_LD)
   ) u_hz (
      .valid  (iss_valid),
      .cls    (cls),
      .src_a  (iss_src_a),
      .src_b  (iss_src_b),
      .rem    (rem),
      .tag_fp (tag_fp),
      .hazard (hazard)
   );

   ilk_stall_ctr #(
      .CNT_W   (CNT_W),
      .SAT_CNT (SAT_CNT)
   ) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (hazard),
      .cnt   (stall_cnt)
   );

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
   parameter int RW     = 5,
   parameter int CNT_W  = 16,
   parameter int LAT_FF = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iss_valid,
   input logic [1:0]       iss_cls,
   input logic [RW-1:0]    iss_dst,
   input logic [RW-1:0]    iss_src_a,
   input logic             stall,
   input logic [CNT_W-1:0] stall_cnt
);

   assert_stall_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> iss_valid);

   assert_int_nostall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_cls == 2'd0) |-> !stall);

   assert_load_nostall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_cls == 2'd2) |-> !stall);

   assert_fp_dep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !stall && iss_cls == 2'd1)
      |=> (LAT_FF == 0 || !(iss_valid && iss_cls == 2'd1 && iss_src_a == $past(iss_dst)) || stall));

   assert_cnt_inc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && stall_cnt != '1) |=> stall_cnt == CNT_W'($past(stall_cnt) + 1'b1));

   assert_cnt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |=> $stable(stall_cnt));

endmodule

bind fp_interlock ilk_checker #(
   .RW     (RW),
   .CNT_W  (CNT_W),
   .LAT_FF (LAT_FF)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iss_valid (iss_valid),
   .iss_cls   (iss_cls),
   .iss_dst   (iss_dst),
   .iss_src_a (iss_src_a),
   .stall     (stall),
   .stall_cnt (stall_cnt)
);

// File: tb/fp_interlock_tb.sv
module fp_interlock_tb;

   localparam int CLK_P  = 10;
   localparam int CNT_W  = 4;
   localparam int RW     = 5;
   localparam logic [1:0] C_INT = 2'd0;
   localparam logic [1:0] C_FPU = 2'd1;
   localparam logic [1:0] C_LDD = 2'd2;
   localparam logic [1:0] C_STD = 2'd3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             iss_valid = 1'b0;
   logic [1:0]       iss_cls = '0;
   logic [RW-1:0]    iss_dst = '0;
   logic [RW-1:0]    iss_src_a = '0;
   logic [RW-1:0]    iss_src_b = '0;
   logic             stall;
   logic [CNT_W-1:0] stall_cnt;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_P/2) clk = ~clk;

   fp_interlock #(.CNT_W(CNT_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_valid (iss_valid),
      .iss_cls   (iss_cls),
      .iss_dst   (iss_dst),
      .iss_src_a (iss_src_a),
      .iss_src_b (iss_src_b),
      .stall     (stall),
      .stall_cnt (stall_cnt)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: run hung after %0d cycles (expected completion)", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      iss_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // present one instruction, hold it while stalled, return stalled cycles
   task automatic issue(input logic [1:0] c, input int d, input int a, input int b,
                        output int ns);
      iss_valid = 1'b1;
      iss_cls   = c;
      iss_dst   = RW'(d);
      iss_src_a = RW'(a);
      iss_src_b = RW'(b);
      ns = 0;
      #1;
      while (stall && ns < 40) begin
         ns++;
         @(negedge clk);
         #1;
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      iss_valid = 1'b0;
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      int ns;
      do_reset();
      #1;
      check("R1 stall after reset", int'(stall), 0);
      check("R1 counter after reset", int'(stall_cnt), 0);
      issue(C_FPU, 3, 4, 5, ns);
      check("R1 first consumer unstalled", ns, 0);
      idle(1);
   endtask

   task automatic t_fp_fp();
      int ns;
      do_reset();
      issue(C_FPU, 4, 1, 2, ns);
      issue(C_FPU, 7, 3, 4, ns);
      check("R3 fp->fp stalls", ns, 3);
      idle(1);
      check("R11 counter after fp->fp", int'(stall_cnt), 3);
   endtask

   task automatic t_fp_st();
      int ns;
      do_reset();
      issue(C_FPU, 4, 1, 2, ns);
      issue(C_STD, 0, 4, 0, ns);
      check("R4 fp->store stalls", ns, 2);
      idle(1);
   endtask

   task automatic t_ld_fp();
      int ns;
      do_reset();
      issue(C_LDD, 2, 0, 0, ns);
      issue(C_FPU, 8, 2, 0, ns);
      check("R5 load->fp stalls", ns, 1);
      idle(1);
   endtask

   task automatic t_ld_st();
      int ns;
      do_reset();
      issue(C_LDD, 6, 0, 0, ns);
      issue(C_STD, 0, 6, 0, ns);
      check("R6 load->store stalls", ns, 0);
      idle(1);
      check("R6 counter unchanged", int'(stall_cnt), 0);
   endtask

   task automatic t_gap();
      int ns;
      do_reset();
      issue(C_FPU, 4, 1, 2, ns);
      issue(C_INT, 4, 4, 4, ns);
      check("R8 integer between unstalled", ns, 0);
      issue(C_FPU, 9, 4, 1, ns);
      check("R7 one gap instruction", ns, 2);
      issue(C_FPU, 10, 1, 2, ns);
      issue(C_INT, 0, 0, 0, ns);
      issue(C_INT, 0, 0, 0, ns);
      issue(C_FPU, 11, 2, 10, ns);
      check("R7 two gap instructions", ns, 1);
      idle(1);
   endtask

   task automatic t_ignored();
      int ns;
      do_reset();
      issue(C_FPU, 4, 1, 2, ns);
      issue(C_STD, 0, 9, 4, ns);
      check("R8 store src_b ignored", ns, 0);
      issue(C_LDD, 1, 4, 4, ns);
      check("R8 load sources ignored", ns, 0);
      issue(C_INT, 4, 4, 4, ns);
      check("R8 integer sources ignored", ns, 0);
      idle(1);
      check("R8 counter unchanged", int'(stall_cnt), 0);
   endtask

   task automatic t_waw();
      int ns;
      do_reset();
      issue(C_FPU, 4, 1, 2, ns);
      issue(C_LDD, 4, 0, 0, ns);
      issue(C_FPU, 12, 4, 1, ns);
      check("R9 newest producer sets latency", ns, 1);
      idle(1);
   endtask

   task automatic t_valid();
      int ns;
      do_reset();
      issue(C_FPU, 4, 1, 2, ns);
      iss_valid = 1'b0;
      iss_cls   = C_FPU;
      iss_src_a = RW'(4);
      #1;
      check("R10 no stall without valid", int'(stall), 0);
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      issue(C_FPU, 13, 4, 4, ns);
      check("R10 consumer after idle cycles", ns, 0);
      idle(1);
      check("R10 counter with idle hazard", int'(stall_cnt), 0);
   endtask

   task automatic t_daxpy();
      int ns;
      int tot;
      do_reset();
      for (int it = 0; it < 2; it++) begin
         tot = 0;
         issue(C_LDD, 2, 0, 0, ns);  tot += ns;
         issue(C_FPU, 4, 2, 0, ns);  tot += ns;
         issue(C_LDD, 6, 0, 0, ns);  tot += ns;
         issue(C_FPU, 6, 4, 6, ns);  tot += ns;
         issue(C_STD, 0, 6, 0, ns);  tot += ns;
         issue(C_INT, 0, 0, 0, ns);  tot += ns;
         issue(C_INT, 0, 0, 0, ns);  tot += ns;
         issue(C_INT, 0, 0, 0, ns);  tot += ns;
         issue(C_INT, 0, 0, 0, ns);  tot += ns;
         issue(C_INT, 0, 6, 4, ns);  tot += ns;
         check("R2 loop stalls per iteration", tot, 5);
      end
      idle(1);
      check("R11 loop counter", int'(stall_cnt), 10);
   endtask

   task automatic t_sat();
      int ns;
      do_reset();
      for (int k = 0; k < 7; k++) issue(C_FPU, 1, 1, 1, ns);
      idle(2);
      check("R11 counter saturates", int'(stall_cnt), 15);
   endtask

   initial begin
      t_reset();
      t_fp_fp();
      t_fp_st();
      t_ld_fp();
      t_ld_st();
      t_gap();
      t_ignored();
      t_waw();
      t_valid();
      t_daxpy();
      t_sat();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule